// File: doc/BRIEF.md
# Dual-CAS DRAM Strobe Decoder

This block is a synthesizable, clock-sampled model of the device side of a 16-bit asynchronous DRAM with one column strobe for each byte. It watches the row strobe, the upper and lower column strobes, write enable and output enable on every clock edge. From those strobes it works out what kind of cycle the controller ran. It latches the row and column addresses, writes a small internal array one byte lane at a time, and decides for each byte whether the data pins would be driven. It is meant to sit in a controller test environment as a target whose behaviour can be checked at clock resolution. Analog timing is not modelled.

The cycle mode follows the combined column strobe. That strobe opens when the first byte strobe falls and closes only when both byte strobes are high again. Writes and output drive, in contrast, follow each byte's own strobe. A row-strobe fall while a column strobe is low starts a refresh that uses an internal counter. A row-strobe fall with both column strobes high opens a row. If no column strobe falls before the row strobe rises, that cycle was a row-only refresh. Forbidden strobe orderings set a sticky error flag.

Top module: `dual_cas_dram`

## Requirements
- R1: After reset, `dq_oe` is 0, `cyc_mode` is 0 (no cycle yet), `ref_cnt` is 0 and `seq_err` is 0.
- R2: Bit 1 of `dq_oe` belongs to the upper lane (`ucas_n`) and bit 0 to the lower lane (`lcas_n`). A bit is 1 in the cycle after an edge at which, within an open read access, `ras_n`, that lane's column strobe and `oe_n` are low and `we_n` is high. It is 0 after any edge at which `ras_n`, `ucas_n` and `lcas_n` are all high, or `oe_n` is high.
- R3: If `ras_n` falls at an edge where either column strobe is low, the cycle is a CAS-before-RAS refresh. `ref_cnt` rises by one at that edge, nothing is written, `dq_oe` stays 0, and `cyc_mode` reads 5 once `ras_n` rises.
- R4: The refresh counter is `REF_W` (9) bits wide and wraps from 511 to 0.
- R5: If `ras_n` falls with both column strobes high and rises again with no column strobe fall in between, `cyc_mode` reads 4 and no stored data changes.
- R6: If `we_n` is low at the edge where the combined column strobe opens, the access is an early write. Each lane whose own strobe falls with `we_n` low stores its byte of `dq_in`. `dq_oe` stays 0, and `cyc_mode` reads 2 after `ras_n` rises.
- R7: If `we_n` falls while the access is open and was not opened as a write, the access is a delayed write. `dq_in` at the `we_n` fall edge is stored into each lane whose strobe is then low, and `cyc_mode` reads 3 after `ras_n` rises.
- R8: In a read, `dq_out` holds the word stored at index {row[ROW_BITS-1:0], col[COL_BITS-1:0]} one cycle after the column strobe falls. Higher address bits are ignored, and `cyc_mode` reads 1 after `ras_n` rises.
- R9: A write with only one byte strobe active leaves the other byte of the stored word unchanged.
- R10: When the byte strobes fall on different edges in a read, the column address is the one on `addr` when the first strobe fell.
- R11: A byte strobe that falls after the access opened sets `seq_err` if the access is a write or `we_n` is low at that edge (mixed byte modes or a staggered write). `seq_err` stays set until reset.
- R12: Within one row-strobe low period, each new opening of the combined column strobe after both byte strobes were high latches a new column (page mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper byte column strobe, active low |
| lcas_n | input | 1 | Lower byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DATA_W | Write data |
| dq_out | output | DATA_W | Read data word |
| dq_oe | output | 2 | Per-lane drive enable (bit 1 upper, bit 0 lower) |
| cyc_mode | output | 3 | Class of the last completed row cycle |
| ref_cnt | output | REF_W | Internal refresh counter value |
| seq_err | output | 1 | Sticky forbidden-sequence flag |

## Verification
A vector table runs early writes, delayed writes and reads with both lanes and with a single lane. This tells per-lane write masking apart from whole-word writes, and shows that upper address bits alias onto the same word. Directed sequences then run a row-only refresh between reads, to show it leaves the data alone. Refresh cycles that begin with only the upper strobe low are run long enough to roll the counter over. Reads with the byte strobes falling on different edges and at different addresses show that the first strobe sets the column. A second column opening in the same row shows page mode. Finally, an early write on one lane followed by a late read-mode fall on the other shows the sticky error flag, which then survives a clean read.

// File: rtl/dcas_pkg.sv
package dcas_pkg;

   typedef enum logic [2:0] {
      MODE_NONE = 3'd0,
      MODE_READ = 3'd1,
      MODE_EWR  = 3'd2,
      MODE_DWR  = 3'd3,
      MODE_ROR  = 3'd4,
      MODE_CBR  = 3'd5
   } cyc_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ROW,
      ST_PAGE,
      ST_CBR
   } ctl_state_e;

   localparam int LANES = 2;

endpackage

// File: rtl/dcas_strobe_edges.sv
module dcas_strobe_edges #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_n,
   output logic [N-1:0] fall_o,
   output logic [N-1:0] hist_n
);

   for (genvar i = 0; i < N; i++) begin : g_edge
      always_ff @(posedge clk) begin
         if (!rst_n) hist_n[i] <= 1'b1;
         else        hist_n[i] <= lvl_n[i];
      end
      assign fall_o[i] = hist_n[i] & ~lvl_n[i];
   end

endmodule

// File: rtl/dcas_byte_lane.sv
module dcas_byte_lane #(
   parameter int BW    = 8,
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [BW-1:0]    wdata,
   input  logic             drv_req,
   output logic [BW-1:0]    rdata,
   output logic             drv
);

   localparam int DEPTH = 1 << IDX_W;

   logic [BW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[idx] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
         drv   <= 1'b0;
      end else begin
         rdata <= store[idx];
         drv   <= drv_req;
      end
   end

endmodule

// File: rtl/dcas_cycle_ctl.sv
module dcas_cycle_ctl
   import dcas_pkg::*;
#(
   parameter int ADDR_W   = 9,
   parameter int ROW_BITS = 3,
   parameter int COL_BITS = 3,
   parameter int REF_W    = 9,
   localparam int IDX_W   = ROW_BITS + COL_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic [1:0]        cas_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ras_fall,
   input  logic              ras_hist_n,
   input  logic [1:0]        cas_fall,
   input  logic [1:0]        cas_hist_n,
   input  logic              we_fall,
   output logic [1:0]        wr_en,
   output logic [IDX_W-1:0]  idx,
   output logic              drv_ok,
   output logic [2:0]        mode,
   output logic [REF_W-1:0]  ref_cnt,
   output logic              err
);

   ctl_state_e        st_q, st_n;
   cyc_mode_e         mode_q, mode_n;
   logic [ADDR_W-1:0] row_q, row_n, col_q, col_n;
   logic              early_q, early_n, dly_q, dly_n;
   logic [REF_W-1:0]  ref_q, ref_n;
   logic              err_q, err_n;

   logic       any_low_now, any_low_hist, comb_fall, ras_rise, row_open;
   logic [1:0] late_fall, early_wr, dly_wr;

   assign any_low_now  = ~&cas_n;
   assign any_low_hist = ~&cas_hist_n;
   assign comb_fall    = any_low_now & ~any_low_hist;
   assign ras_rise     = ~ras_hist_n & ras_n;
   assign row_open     = ((st_q == ST_ROW) || (st_q == ST_PAGE)) && !ras_n;

   for (genvar b = 0; b < LANES; b++) begin : g_lane_dec
      assign late_fall[b] = cas_fall[b] & ~comb_fall & (st_q == ST_PAGE) & ~ras_n;
      assign early_wr[b]  = row_open & cas_fall[b] & ~we_n;
      assign dly_wr[b]    = (st_q == ST_PAGE) & ~ras_n & we_fall & ~cas_n[b]
                            & ~cas_fall[b] & ~early_q;
   end

   assign wr_en = early_wr | dly_wr;

   always_comb begin
      st_n    = st_q;
      mode_n  = mode_q;
      row_n   = row_q;
      col_n   = col_q;
      early_n = early_q;
      dly_n   = dly_q;
      ref_n   = ref_q;
      unique case (st_q)
         ST_IDLE: begin
            if (ras_fall) begin
               if (any_low_now) begin
                  st_n  = ST_CBR;
                  ref_n = ref_q + 1'b1;
               end else begin
                  st_n  = ST_ROW;
                  row_n = addr;
               end
            end
         end
         ST_ROW: begin
            if (ras_n) begin
               st_n   = ST_IDLE;
               mode_n = MODE_ROR;
            end else if (comb_fall) begin
               st_n    = ST_PAGE;
               col_n   = addr;
               early_n = ~we_n;
               dly_n   = 1'b0;
            end
         end
         ST_PAGE: begin
            if (ras_n) begin
               st_n   = ST_IDLE;
               mode_n = early_q ? MODE_EWR : (dly_q ? MODE_DWR : MODE_READ);
            end else if (comb_fall) begin
               col_n   = addr;
               early_n = ~we_n;
               dly_n   = 1'b0;
            end else if (|dly_wr) begin
               dly_n = 1'b1;
            end
         end
         ST_CBR: begin
            if (ras_n) begin
               st_n   = ST_IDLE;
               mode_n = MODE_CBR;
            end
         end
         default: st_n = ST_IDLE;
      endcase
      err_n = err_q | (|(late_fall & {LANES{early_q | dly_q | ~we_n}}));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         mode_q  <= MODE_NONE;
         row_q   <= '0;
         col_q   <= '0;
         early_q <= 1'b0;
         dly_q   <= 1'b0;
         ref_q   <= '0;
         err_q   <= 1'b0;
      end else begin
         st_q    <= st_n;
         mode_q  <= mode_n;
         row_q   <= row_n;
         col_q   <= col_n;
         early_q <= early_n;
         dly_q   <= dly_n;
         ref_q   <= ref_n;
         err_q   <= err_n;
      end
   end

   logic unused_ctl;
   assign unused_ctl = ^{row_n, col_n, ras_rise};

   assign idx     = {row_n[ROW_BITS-1:0], col_n[COL_BITS-1:0]};
   assign drv_ok  = (st_n == ST_PAGE) & ~early_n;
   assign mode    = mode_q;
   assign ref_cnt = ref_q;
   assign err     = err_q;

endmodule

// File: rtl/dual_cas_dram.sv
module dual_cas_dram #(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 9,
   parameter int ROW_BITS = 3,
   parameter int COL_BITS = 3,
   parameter int REF_W    = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              ucas_n,
   input  logic              lcas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic [1:0]        dq_oe,
   output logic [2:0]        cyc_mode,
   output logic [REF_W-1:0]  ref_cnt,
   output logic              seq_err
);

   localparam int BYTE_W = DATA_W / 2;
   localparam int IDX_W  = ROW_BITS + COL_BITS;
   localparam int NSTRB  = 4;
   localparam int S_LCAS = 0;
   localparam int S_UCAS = 1;
   localparam int S_RAS  = 2;
   localparam int S_WE   = 3;

   if (DATA_W % 2 != 0) begin : g_bad_width
      $error("DATA_W must split into two equal byte lanes");
   end
   if (ROW_BITS > ADDR_W || COL_BITS > ADDR_W) begin : g_bad_index
      $error("ROW_BITS and COL_BITS must not exceed ADDR_W");
   end
   if (IDX_W > 10) begin : g_bad_depth
      $error("array index wider than 10 bits is too large for this model");
   end

   logic [NSTRB-1:0] strb_n, strb_fall, strb_hist_n;
   logic [1:0]       cas_v;
   logic [1:0]       wr_en;
   logic [IDX_W-1:0] idx;
   logic             drv_ok;

   assign cas_v  = {ucas_n, lcas_n};
   assign strb_n = {we_n, ras_n, ucas_n, lcas_n};

   dcas_strobe_edges #(.N(NSTRB)) u_edges (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_n  (strb_n),
      .fall_o (strb_fall),
      .hist_n (strb_hist_n)
   );

   dcas_cycle_ctl #(
      .ADDR_W   (ADDR_W),
      .ROW_BITS (ROW_BITS),
      .COL_BITS (COL_BITS),
      .REF_W    (REF_W)
   ) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ras_n      (ras_n),
      .cas_n      (cas_v),
      .we_n       (we_n),
      .addr       (addr),
      .ras_fall   (strb_fall[S_RAS]),
      .ras_hist_n (strb_hist_n[S_RAS]),
      .cas_fall   ({strb_fall[S_UCAS], strb_fall[S_LCAS]}),
      .cas_hist_n ({strb_hist_n[S_UCAS], strb_hist_n[S_LCAS]}),
      .we_fall    (strb_fall[S_WE]),
      .wr_en      (wr_en),
      .idx        (idx),
      .drv_ok     (drv_ok),
      .mode       (cyc_mode),
      .ref_cnt    (ref_cnt),
      .err        (seq_err)
   );

   for (genvar b = 0; b < 2; b++) begin : g_lane
      logic drv_req;
      assign drv_req = drv_ok & ~cas_v[b] & ~ras_n & we_n & ~oe_n;

      dcas_byte_lane #(.BW(BYTE_W), .IDX_W(IDX_W)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en[b]),
         .idx     (idx),
         .wdata   (dq_in[b*BYTE_W +: BYTE_W]),
         .drv_req (drv_req),
         .rdata   (dq_out[b*BYTE_W +: BYTE_W]),
         .drv     (dq_oe[b])
      );
   end

   logic unused_top;
   assign unused_top = ^{strb_hist_n[S_WE], strb_fall[S_UCAS], strb_fall[S_LCAS]};

endmodule

// File: rtl/dcas_checker.sv
module dcas_checker #(
   parameter int REF_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ras_n,
   input logic             ucas_n,
   input logic             lcas_n,
   input logic             we_n,
   input logic             oe_n,
   input logic [1:0]       dq_oe,
   input logic [REF_W-1:0] ref_cnt,
   input logic             seq_err
);

   logic seen;
   always_ff @(posedge clk) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   // R2: all strobes high leaves both lanes undriven
   p_open_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_n && ucas_n && lcas_n) |=> (dq_oe == 2'b00));

   // R2: output enable high blocks drive
   p_oe_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |=> (dq_oe == 2'b00));

   // R2: upper lane is driven only under its own strobe
   p_upper_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ucas_n |=> !dq_oe[1]);

   // R3: CAS-before-RAS advances the counter by one, modulo its width
   p_cbr_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $past(ras_n) && !ras_n && (!ucas_n || !lcas_n))
      |=> (ref_cnt == REF_W'($past(ref_cnt) + 1'b1)));

   // R6: write enable low keeps the outputs open
   p_early_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |=> (dq_oe == 2'b00));

   // R11: the error flag stays set
   p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |=> seq_err);

endmodule

bind dual_cas_dram dcas_checker #(.REF_W(REF_W)) u_dcas_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ras_n   (ras_n),
   .ucas_n  (ucas_n),
   .lcas_n  (lcas_n),
   .we_n    (we_n),
   .oe_n    (oe_n),
   .dq_oe   (dq_oe),
   .ref_cnt (ref_cnt),
   .seq_err (seq_err)
);

// File: tb/tb_dual_cas_dram.sv
module tb_dual_cas_dram;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [8:0]  addr = '0;
   logic [15:0] dq_in = '0;
   logic [15:0] dq_out;
   logic [1:0]  dq_oe;
   logic [2:0]  cyc_mode;
   logic [8:0]  ref_cnt;
   logic        seq_err;

   int total = 0;
   int bad   = 0;
   logic [15:0] model [64];
   int exp_ref = 0;

   always #2.5 clk = ~clk;

   dual_cas_dram dut (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
      .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
      .dq_oe(dq_oe), .cyc_mode(cyc_mode), .ref_cnt(ref_cnt), .seq_err(seq_err)
   );

   // op: 0 early write, 1 delayed write, 2 read; fields op,row,col,data,lanes
   localparam int NV = 11;
   localparam logic [27:0] VEC [NV] = '{
      {2'd0, 4'd1, 4'd2, 16'hA5C3, 2'b11},
      {2'd2, 4'd1, 4'd2, 16'h0000, 2'b11},
      {2'd1, 4'd2, 4'd5, 16'h1234, 2'b11},
      {2'd2, 4'd2, 4'd5, 16'h0000, 2'b11},
      {2'd0, 4'd1, 4'd2, 16'h77EE, 2'b01},
      {2'd2, 4'd1, 4'd2, 16'h0000, 2'b11},
      {2'd1, 4'd2, 4'd5, 16'hBEEF, 2'b10},
      {2'd2, 4'd2, 4'd5, 16'h0000, 2'b11},
      {2'd0, 4'd9, 4'd3, 16'hCAFE, 2'b11},
      {2'd2, 4'd1, 4'd3, 16'h0000, 2'b11},
      {2'd2, 4'd2, 4'd5, 16'h0000, 2'b10}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic idle();
      ras_n = 1; ucas_n = 1; lcas_n = 1; we_n = 1; oe_n = 1;
      tick();
   endtask

   function automatic int ix(input logic [3:0] row, input logic [3:0] col);
      return {26'd0, row[2:0], col[2:0]};
   endfunction

   task automatic model_wr(input logic [3:0] row, input logic [3:0] col,
                           input logic [15:0] data, input logic [1:0] lanes);
      if (lanes[1]) model[ix(row, col)][15:8] = data[15:8];
      if (lanes[0]) model[ix(row, col)][7:0]  = data[7:0];
   endtask

   task automatic wr_early(input logic [3:0] row, input logic [3:0] col,
                           input logic [15:0] data, input logic [1:0] lanes);
      idle();
      addr = {5'd0, row}; ras_n = 0; tick();
      addr = {5'd0, col}; dq_in = data; we_n = 0; oe_n = 0;
      ucas_n = ~lanes[1]; lcas_n = ~lanes[0]; tick();
      check("R6 early write output open", dq_oe, 2'b00);
      ucas_n = 1; lcas_n = 1; ras_n = 1; tick();
      check("R6 early write mode", cyc_mode, 3'd2);
      model_wr(row, col, data, lanes);
   endtask

   task automatic wr_delayed(input logic [3:0] row, input logic [3:0] col,
                             input logic [15:0] data, input logic [1:0] lanes);
      idle();
      addr = {5'd0, row}; ras_n = 0; tick();
      addr = {5'd0, col}; ucas_n = ~lanes[1]; lcas_n = ~lanes[0]; tick();
      dq_in = data; we_n = 0; tick();
      ucas_n = 1; lcas_n = 1; ras_n = 1; tick();
      check("R7 delayed write mode", cyc_mode, 3'd3);
      model_wr(row, col, data, lanes);
   endtask

   task automatic do_read(input logic [3:0] row, input logic [3:0] col,
                          input logic [1:0] lanes, input string tag);
      logic [15:0] exp;
      idle();
      addr = {5'd0, row}; ras_n = 0; tick();
      addr = {5'd0, col}; oe_n = 0; ucas_n = ~lanes[1]; lcas_n = ~lanes[0]; tick();
      exp = model[ix(row, col)];
      check({tag, " lane drive"}, dq_oe, lanes);
      if (lanes[1]) check({tag, " upper data"}, dq_out[15:8], exp[15:8]);
      if (lanes[0]) check({tag, " lower data"}, dq_out[7:0], exp[7:0]);
      ucas_n = 1; lcas_n = 1; ras_n = 1; oe_n = 1; tick();
      check({tag, " read mode"}, cyc_mode, 3'd1);
      check("R2 idle outputs open", dq_oe, 2'b00);
   endtask

   task automatic cbr_upper();
      idle();
      ucas_n = 0; tick();
      ras_n = 0; oe_n = 0; tick();
      exp_ref = (exp_ref + 1) % 512;
      check("R3 no drive in refresh", dq_oe, 2'b00);
      ras_n = 1; ucas_n = 1; oe_n = 1; tick();
   endtask

   initial begin
      repeat (4) tick();
      rst_n = 1; tick();
      // R1 reset state
      check("R1 reset dq_oe", dq_oe, 2'b00);
      check("R1 reset mode", cyc_mode, 3'd0);
      check("R1 reset refresh count", ref_cnt, 9'd0);
      check("R1 reset error", seq_err, 1'b0);

      // vector table walk
      for (int i = 0; i < NV; i++) begin
         logic [27:0] v;
         v = VEC[i];
         case (v[27:26])
            2'd0: wr_early(v[25:22], v[21:18], v[17:2], v[1:0]);
            2'd1: wr_delayed(v[25:22], v[21:18], v[17:2], v[1:0]);
            default: do_read(v[25:22], v[21:18], v[1:0], "R8/R9/R2");
         endcase
      end

      // R2: output enable high during a read
      idle();
      addr = 9'd1; ras_n = 0; tick();
      addr = 9'd2; ucas_n = 0; lcas_n = 0; tick();
      check("R2 oe high no drive", dq_oe, 2'b00);
      idle();

      // R5: row-only refresh leaves data intact
      addr = 9'd1; ras_n = 0; tick();
      tick();
      ras_n = 1; tick();
      check("R5 row-only mode", cyc_mode, 3'd4);
      do_read(4'd1, 4'd2, 2'b11, "R5 after row-only");

      // R3: CAS-before-RAS with only the upper strobe low
      cbr_upper();
      check("R3 refresh count", ref_cnt, exp_ref[8:0]);
      check("R3 refresh mode", cyc_mode, 3'd5);
      do_read(4'd1, 4'd2, 2'b11, "R3 data after refresh");

      // R4: wrap of the refresh counter
      for (int k = 0; k < 510; k++) cbr_upper();
      check("R4 count at top", ref_cnt, 9'd511);
      cbr_upper();
      check("R4 count wraps", ref_cnt, 9'd0);

      // R10: staggered byte strobes in a read
      wr_early(4'd3, 4'd1, 16'h1111, 2'b11);
      wr_early(4'd3, 4'd6, 16'h2222, 2'b11);
      idle();
      addr = 9'd3; ras_n = 0; tick();
      addr = 9'd1; oe_n = 0; lcas_n = 0; tick();
      addr = 9'd6; ucas_n = 0; tick();
      check("R10 staggered drive", dq_oe, 2'b11);
      check("R10 first strobe column", dq_out, 16'h1111);
      check("R11 staggered read is legal", seq_err, 1'b0);

      // R12: page mode, second column in the same row
      ucas_n = 1; lcas_n = 1; tick();
      check("R12 gap undriven", dq_oe, 2'b00);
      addr = 9'd6; ucas_n = 0; lcas_n = 0; tick();
      check("R12 second column data", dq_out, 16'h2222);
      ucas_n = 1; lcas_n = 1; ras_n = 1; oe_n = 1; tick();
      check("R12 page read mode", cyc_mode, 3'd1);

      // R11: mixed byte modes set a sticky error
      idle();
      addr = 9'd4; ras_n = 0; tick();
      addr = 9'd0; dq_in = 16'h5A5A; we_n = 0; lcas_n = 0; tick();
      we_n = 1; ucas_n = 0; tick();
      check("R11 mixed modes flagged", seq_err, 1'b1);
      idle();
      model_wr(4'd4, 4'd0, 16'h5A5A, 2'b01);
      do_read(4'd1, 4'd3, 2'b11, "R11 clean read");
      check("R11 error stays set", seq_err, 1'b1);

      // R1: reset clears the flag and the mode
      rst_n = 0; tick(); tick();
      rst_n = 1; tick();
      check("R1 reset clears error", seq_err, 1'b0);
      check("R1 reset clears mode", cyc_mode, 3'd0);
      check("R1 reset clears count", ref_cnt, 9'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule